// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers nine interrupt request lines from the peripherals of a small microcontroller core. Each request sets its own posted bit, and that bit stays set until the CPU services the source or software clears it. A per-source mask decides which posted bits are pending. A pending bit is visible to a fixed-priority encoder. A masked bit stays posted and keeps collecting events, but the encoder does not see it.

The encoder picks the pending source with the lowest index and drives its vector address, which is the index times four. It raises the request line to the CPU only while the global enable is set. When the CPU takes the interrupt, the controller clears the posted bit of the vector that was taken and drops the global enable. A return strobe sets the global enable again, so any source still pending is requested again straight away.

The source indices, from highest priority to lowest, are: 0 reset, 1 supply monitor, 2 analog, 3 capacitive sense, 4 timer, 5 GPIO, 6 SPI, 7 I2C, 8 sleep timer. A small register bus gives software four word addresses:
- 0: mask (read/write).
- 1: clear (write) and the posted bits (read).
- 2: software set (write) and the pending bits (read).
- 3: global enable in bit 0.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all posted bits, all mask bits and the global enable read 0, and `irqReq` is 0.
- R2: A 1 on `srcEvent[i]` at a clock edge sets posted bit i. Read at address 1, bit i, the bit stays set until it is cleared or taken.
- R3: The pending bits, read at address 2, equal the posted bits AND the mask bits.
- R4: Clearing a mask bit leaves its posted bit unchanged, and new events still set that posted bit while it is masked.
- R5: When any bit is pending, `vecAddr` equals 4 times the lowest pending index, so vectors run from 0x00 for index 0 to 0x20 for index 8. With nothing pending, `vecAddr` is 0.
- R6: `irqReq` is 1 exactly when at least one bit is pending and the global enable is 1.
- R7: An `irqTake` pulse while `irqReq` is 1 has two effects at that edge. It clears only the posted bit of the index shown on `vecAddr`, and it clears the global enable.
- R8: An `irqReturn` pulse sets the global enable. A write to address 3 loads the global enable from bit 0.
- R9: A write to address 1 clears every posted bit whose data bit (bits 8..0) is 1. If data bit 15 is 1, the write clears all posted bits.
- R10: A write to address 2 sets every posted bit whose data bit (bits 8..0) is 1.
- R11: A hardware event and a clear of the same bit in the same cycle leave the posted bit set.
- R12: An `irqTake` pulse while `irqReq` is 0 changes no posted bit and no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvent | input | 9 | Per-source interrupt events, active high |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register word address |
| busWData | input | 16 | Register write data |
| busRData | output | 16 | Register read data (mask, posted, pending, enable) |
| irqTake | input | 1 | CPU takes the requested interrupt |
| irqReturn | input | 1 | CPU returns from service; sets the global enable |
| irqReq | output | 1 | Interrupt request to the CPU |
| vecAddr | output | 8 | Vector address of the highest-priority pending source |
| gieOut | output | 1 | Current global enable |

## Verification
The bench walks mask and posted patterns that hide the highest posted source behind the mask. A design that encodes posted bits instead of pending bits would then give the wrong vector. It checks that a masked source still posts and that a mask change leaves it posted. A design that folded the mask into the posted register would lose those events. It races a hardware event against a clear of the same bit, where a clear-wins design would drop the event. It also checks that a take clears only the chosen source and that a take with no request is ignored. A careless design would wipe other posted bits or drop the enable without a request.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Register word addresses
  localparam logic [1:0] ADDR_MASK  = 2'd0;
  localparam logic [1:0] ADDR_CLEAR = 2'd1;
  localparam logic [1:0] ADDR_SET   = 2'd2;
  localparam logic [1:0] ADDR_GIE   = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic maskWe;
    logic clrWe;
    logic clrAll;
    logic setWe;
    logic takeFire;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC  = 9,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  ctlStrobe_t         strb,
  input  logic [NUM_SRC-1:0] wBits,
  output logic [NUM_SRC-1:0] posted,
  output logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] pending,
  output logic               anyPend,
  output logic [VEC_W-1:0]   vecAddr
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0]   selIdx;
  logic [NUM_SRC-1:0] takeVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] keepMask;

  // Mask register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            mask <= '0;
    else if (strb.maskWe) mask <= wBits;
  end

  assign clrVec   = strb.clrAll ? '1 : (strb.clrWe ? wBits : '0);
  assign setVec   = strb.setWe ? wBits : '0;
  assign takeVec  = strb.takeFire ? (NUM_SRC'(1) << selIdx) : '0;
  assign keepMask = posted & ~clrVec & ~takeVec;

  // One posted flop per source; events and software sets win over clears
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_post
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        posted[i] <= 1'b0;
      else if (srcEvent[i] || setVec[i])
        posted[i] <= 1'b1;
      else if (clrVec[i] || takeVec[i])
        posted[i] <= 1'b0;
    end
  end

  assign pending = posted & mask;
  assign anyPend = |pending;

  // Fixed-priority encoder: lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) selIdx = IDX_W'(i);
    end
  end

  assign vecAddr = anyPend ? (VEC_W'(selIdx) * VEC_W'(VEC_STEP)) : '0;

  // R2 and R11: a sampled event always leaves its posted bit set
  a_r2_event_posts: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvent) |=> ((posted & $past(srcEvent)) == $past(srcEvent)));

  // R4: posted bits fall only through a clear or a take, never through the mask
  a_r4_mask_keeps_posted: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((posted & $past(keepMask)) == $past(keepMask)));

  // R5: the selected index is really pending
  a_r5_sel_pending: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |-> pending[selIdx]);

  // R7: a take retires at most one source
  a_r7_take_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(takeVec));

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CLR_ALL_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWData,
  input  logic              irqTake,
  input  logic              irqReturn,
  input  logic              anyPend,
  output ctlStrobe_t        strb,
  output logic              irqReq,
  output logic              gie
);

  always_comb begin
    strb          = '0;
    strb.maskWe   = busWe && (busAddr == ADDR_MASK);
    strb.clrWe    = busWe && (busAddr == ADDR_CLEAR);
    strb.clrAll   = strb.clrWe && busWData[CLR_ALL_BIT];
    strb.setWe    = busWe && (busAddr == ADDR_SET);
    strb.takeFire = irqTake && irqReq;
  end

  assign irqReq = anyPend && gie;

  // Global enable: a take has priority over a return or a register write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              gie <= 1'b0;
    else if (strb.takeFire)                 gie <= 1'b0;
    else if (irqReturn)                     gie <= 1'b1;
    else if (busWe && busAddr == ADDR_GIE)  gie <= busWData[0];
  end

  // R6: no request while the enable is low
  a_r6_req_needs_gie: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> gie);

  // R7: taking an interrupt drops the enable
  a_r7_take_clears_gie: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake && irqReq) |=> !gie);

  // R8: a return restores the enable
  a_r8_return_sets_gie: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && !(irqTake && irqReq)) |=> gie);

  // R12: a take with no request leaves the enable alone
  a_r12_idle_take: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake && !irqReq && !irqReturn && !busWe) |=> $stable(gie));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC     = 9,
  parameter int DATA_W      = 16,
  parameter int VEC_W       = 8,
  parameter int VEC_STEP    = 4,
  parameter int CLR_ALL_BIT = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               busWe,
  input  logic [1:0]         busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  input  logic               irqTake,
  input  logic               irqReturn,
  output logic               irqReq,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               gieOut
);
  ctlStrobe_t         strb;
  logic [NUM_SRC-1:0] posted;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] pending;
  logic               anyPend;

  irq_prio_ctl #(.DATA_W(DATA_W), .CLR_ALL_BIT(CLR_ALL_BIT)) u_ctl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWData(busWData), .irqTake(irqTake), .irqReturn(irqReturn),
    .anyPend(anyPend), .strb(strb), .irqReq(irqReq), .gie(gieOut)
  );

  irq_prio_dp #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .strb(strb),
    .wBits(busWData[NUM_SRC-1:0]), .posted(posted), .mask(mask),
    .pending(pending), .anyPend(anyPend), .vecAddr(vecAddr)
  );

  always_comb begin
    busRData = '0;
    case (busAddr)
      ADDR_MASK:  busRData[NUM_SRC-1:0] = mask;
      ADDR_CLEAR: busRData[NUM_SRC-1:0] = posted;
      ADDR_SET:   busRData[NUM_SRC-1:0] = pending;
      default:    busRData[0]           = gieOut;
    endcase
  end

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  srcEvent = '0;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic        irqTake = 1'b0;
  logic        irqReturn = 1'b0;
  logic        irqReq;
  logic [7:0]  vecAddr;
  logic        gieOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .busWe(busWe),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .irqTake(irqTake), .irqReturn(irqReturn), .irqReq(irqReq),
    .vecAddr(vecAddr), .gieOut(gieOut)
  );

  // {mask, software set, expected vector, expected request}
  localparam logic [26:0] VEC_TBL [8] = '{
    {9'h1FF, 9'h100, 8'h20, 1'b1},
    {9'h1FF, 9'h1FF, 8'h00, 1'b1},
    {9'h1FE, 9'h1FF, 8'h04, 1'b1},
    {9'h0F0, 9'h0A8, 8'h14, 1'b1},
    {9'h000, 9'h1FF, 8'h00, 1'b0},
    {9'h180, 9'h0C0, 8'h1C, 1'b1},
    {9'h010, 9'h010, 8'h10, 1'b1},
    {9'h00C, 9'h1FC, 8'h08, 1'b1}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWe = 1'b0; busWData = '0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #0.5;
    d = busRData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    logic [15:0] rd;
    #5 rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    busRead(0, rd); check("R1 mask", rd, 16'h0);
    busRead(1, rd); check("R1 posted", rd, 16'h0);
    busRead(3, rd); check("R1 gie", rd, 16'h0);
    check("R1 irqReq", {15'h0, irqReq}, 16'h0);

    // R6: pending without enable gives no request
    busWrite(0, 16'h1FF);
    busWrite(2, 16'h002);
    check("R6 no gie", {15'h0, irqReq}, 16'h0);
    busWrite(3, 16'h001);
    check("R8 gie write", {15'h0, gieOut}, 16'h1);

    // R5, R6, R10: table of mask/set patterns
    for (int k = 0; k < 8; k++) begin
      busWrite(1, 16'h8000);
      busWrite(0, {7'h0, VEC_TBL[k][26:18]});
      busWrite(2, {7'h0, VEC_TBL[k][17:9]});
      busRead(1, rd); check("R10 set posted", rd, {7'h0, VEC_TBL[k][17:9]});
      check("R5 vector", {8'h0, vecAddr}, {8'h0, VEC_TBL[k][8:1]});
      check("R6 request", {15'h0, irqReq}, {15'h0, VEC_TBL[k][0]});
    end

    // R9: clear-all, then disable
    busWrite(1, 16'h8000);
    busRead(1, rd); check("R9 clear all", rd, 16'h0);
    busWrite(3, 16'h000);

    // R2: event pulse posts and holds
    @(negedge clk); srcEvent = 9'h008;
    @(negedge clk); srcEvent = '0;
    busRead(1, rd); check("R2 posted", rd, 16'h008);
    repeat (3) @(negedge clk);
    busRead(1, rd); check("R2 hold", rd, 16'h008);

    // R4: masked source still posts; unmasking and remasking keeps it
    busWrite(0, 16'h000);
    @(negedge clk); srcEvent = 9'h040;
    @(negedge clk); srcEvent = '0;
    busRead(1, rd); check("R4 masked posts", rd, 16'h048);
    busWrite(0, 16'h040);
    busRead(2, rd); check("R3 pending", rd, 16'h040);
    busWrite(0, 16'h000);
    busRead(1, rd); check("R4 unmask keeps", rd, 16'h048);
    busRead(2, rd); check("R3 pending masked", rd, 16'h000);

    // R9: per-bit clear
    busWrite(1, 16'h008);
    busRead(1, rd); check("R9 bit clear", rd, 16'h040);

    // R11: event beats clear in the same cycle
    busWrite(2, 16'h004);
    @(negedge clk);
    srcEvent = 9'h004; busWe = 1'b1; busAddr = 2'd1; busWData = 16'h004;
    @(negedge clk);
    srcEvent = '0; busWe = 1'b0; busWData = '0;
    busRead(1, rd); check("R11 event wins", rd, 16'h044);

    // R7: take clears only the selected source and the enable
    busWrite(1, 16'h8000);
    busWrite(2, 16'h030);
    busWrite(0, 16'h1FF);
    busWrite(3, 16'h001);
    check("R7 pre vector", {8'h0, vecAddr}, 16'h0010);
    @(negedge clk); irqTake = 1'b1;
    @(negedge clk); irqTake = 1'b0;
    busRead(1, rd); check("R7 posted after take", rd, 16'h020);
    check("R7 gie cleared", {15'h0, gieOut}, 16'h0);
    check("R7 request drops", {15'h0, irqReq}, 16'h0);
    check("R7 next vector", {8'h0, vecAddr}, 16'h0014);

    // R12: take with no request is ignored
    @(negedge clk); irqTake = 1'b1;
    @(negedge clk); irqTake = 1'b0;
    busRead(1, rd); check("R12 posted kept", rd, 16'h020);
    check("R12 gie kept", {15'h0, gieOut}, 16'h0);

    // R8: return restores the enable and the remaining source is requested
    @(negedge clk); irqReturn = 1'b1;
    @(negedge clk); irqReturn = 1'b0;
    check("R8 gie set", {15'h0, gieOut}, 16'h1);
    check("R8 request again", {15'h0, irqReq}, 16'h1);

    finishRun();
  end
endmodule